// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator machine. It holds a fixed control store of 16-bit microwords and steps through the microwords that belong to the current machine instruction, one per clock. Each microword is cut into six encoded groups: register write, bus driver, address unit, program counter, end marker and ALU operation. Each group is decoded into its own set of one-hot strobes, so one action from every group can fire in the same cycle.

After reset the sequencer issues one idle cycle. It then runs the fetch microword, which loads the instruction register from memory. On the next clock it jumps to the entry microword of the opcode that the instruction register now presents. It walks forward through the microwords of that routine until it issues a microword whose end bit is set. On the following clock it returns to fetch. The datapath registers, the memory and the ALU sit outside the block and only consume the strobes.

Top module: `ucseq_top`

## Requirements
- R1: The current microword appears on `uword_o`, packed as ALU code in bits 3:0, end bit in bit 4, PC code in bits 6:5, address-unit code in bits 9:7, read code in bits 12:10 and write code in bits 15:13.
- R2: Write code c in 1..6 raises only `wr_en_o[c-1]` (1 X, 2 Y, 3 accumulator, 4 page, 5 instruction register, 6 memory). Codes 0 and 7 raise none, so at most one write strobe is high.
- R3: Read code c in 1..7 raises only `rd_en_o[c-1]` (1 X, 2 Y, 3 accumulator, 4 page, 5 instruction register, 6 memory, 7 stack-pointer location). Code 0 raises none, so at most one bus driver is active.
- R4: Address-unit codes map as follows: code 1 (add page) to `au_o[0]`, code 2 (subtract page) to `au_o[1]`, code 4 (stack pointer step) to `au_o[2]`, code 5 (load address register) to `au_o[3]` and code 6 (drive from address register) to `au_o[4]`. Codes 0, 3 and 7 raise none.
- R5: PC code c in 1..3 raises only `pc_o[c-1]` (1 reset, 2 load from bus, 3 load when zero). Code 0 raises none.
- R6: ALU code c in 1..15 raises only `alu_o[c-1]`. Code 0 raises none.
- R7: A synchronous active-high `rst` seen at a clock edge makes the next cycle issue microword 0x0000, with every strobe, `fetch_o` and `end_o` low. A clock edge with `rst` low in that idle cycle moves to fetch.
- R8: The fetch cycle issues microword 0xB800 (write instruction register, read memory) with `fetch_o` high, for exactly one cycle. The opcode is taken as the instruction register contents from the next cycle on.
- R9: After fetch, the sequencer issues the opcode's entry microword and then the following microwords in store order, one per clock. `end_o` follows bit 4 of the microword and `fetch_o` is low.
- R10: The cycle after a microword with the end bit set is a fetch cycle, so a routine runs for exactly as many cycles as it has microwords up to and including the first end bit.
- R11: The routines are as follows. Opcode 0: 0x0010. Opcode 1: 0x7800, 0x0010. Opcode 2: 0x1680, 0xCC10. Opcode 3: 0x5800, 0x6017. Opcode 4: 0x1450. Opcode 5: 0x1470. Opcode 6: 0x3E00, 0x0080, 0x8410. Opcode 7: 0x003F. Opcode 8+k for k in 0..7 has two words. The first has read code 4 if k is odd and 2 if k is even, ALU code k+1, and nothing else. The second has write code 3, address-unit code 6 if k is odd and 2 if k is even, the end bit, and ALU code k+8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 4 | Opcode held by the instruction register |
| uword_o | output | 16 | Microword issued this cycle |
| fetch_o | output | 1 | High during the fetch cycle |
| end_o | output | 1 | End bit of the current microword |
| wr_en_o | output | 6 | One-hot register or memory write strobes |
| rd_en_o | output | 7 | One-hot bus driver enables |
| au_o | output | 5 | One-hot address-unit actions |
| pc_o | output | 3 | One-hot program counter actions |
| alu_o | output | 15 | One-hot ALU operation selects |

## Verification
Assertions check on every cycle that each strobe group stays one-hot or silent, that reserved address-unit codes stay silent, and that reset leads to idle. They also check that fetch is always followed by the first routine word, that a word without the end bit advances the step by one, and that an end word always returns to fetch. Whether each opcode lands on the right entry, whether the routine contents and lengths are correct, and whether every strobe bit matches its code can only be shown by the bench. It runs every opcode directly, then a seeded random stream of opcodes, and applies a reset in the middle of a routine, comparing each issued word and its decoded strobes with its own model.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int UW_W        = 16;
    localparam int OPC_W       = 4;
    localparam int UADDR_W     = 5;
    localparam int STORE_DEPTH = 1 << UADDR_W;
    localparam int STEP_W      = 2;

    localparam int WR_N  = 6;
    localparam int RD_N  = 7;
    localparam int AU_N  = 5;
    localparam int PC_N  = 3;
    localparam int ALU_N = 15;

    localparam int FETCH_ADDR = 0;
    localparam int ALU_BASE   = 14;  // first word of the two-word ALU routines

    localparam logic [UW_W-1:0] UW_IDLE  = 16'h0000;
    localparam logic [UW_W-1:0] UW_FETCH = 16'hB800;
    localparam logic [UW_W-1:0] UW_HALT  = 16'h0010;

    typedef struct packed {
        logic [2:0] wr;
        logic [2:0] rd;
        logic [2:0] au;
        logic [1:0] pc;
        logic       done;
        logic [3:0] alu;
    } uword_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2
    } phase_t;

    // Address-unit strobe index to field code.
    function automatic logic [2:0] au_code(int idx);
        logic [2:0] c;
        case (idx)
            0:       c = 3'd1;
            1:       c = 3'd2;
            2:       c = 3'd4;
            3:       c = 3'd5;
            4:       c = 3'd6;
            default: c = 3'd0;
        endcase
        return c;
    endfunction

    // Entry microword address of each opcode routine.
    function automatic logic [UADDR_W-1:0] entry_of(logic [OPC_W-1:0] op);
        int a;
        case (op)
            4'd0:    a = 1;
            4'd1:    a = 2;
            4'd2:    a = 4;
            4'd3:    a = 6;
            4'd4:    a = 8;
            4'd5:    a = 9;
            4'd6:    a = 10;
            4'd7:    a = 13;
            default: a = ALU_BASE + 2 * (int'(op) - 8);
        endcase
        return UADDR_W'(a);
    endfunction

    // Control store contents, computed per address.
    function automatic logic [UW_W-1:0] store_word(int a);
        uword_t w;
        int     k;
        w = '0;
        k = 0;
        case (a)
            0:  w = UW_FETCH;
            1:  w = UW_HALT;
            2:  w = 16'h7800;
            3:  w = UW_HALT;
            4:  w = 16'h1680;
            5:  w = 16'hCC10;
            6:  w = 16'h5800;
            7:  w = 16'h6017;
            8:  w = 16'h1450;
            9:  w = 16'h1470;
            10: w = 16'h3E00;
            11: w = 16'h0080;
            12: w = 16'h8410;
            13: w = 16'h003F;
            default: begin
                if (a >= ALU_BASE && a < ALU_BASE + 16) begin
                    k = (a - ALU_BASE) / 2;
                    if (((a - ALU_BASE) % 2) == 0) begin
                        w.rd  = (k % 2 == 1) ? 3'd4 : 3'd2;
                        w.alu = 4'(k + 1);
                    end else begin
                        w.wr   = 3'd3;
                        w.au   = (k % 2 == 1) ? 3'd6 : 3'd2;
                        w.done = 1'b1;
                        w.alu  = 4'(k + 8);
                    end
                end else begin
                    w = UW_HALT;
                end
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
    import ucseq_pkg::*;
#(
    parameter int ADDR_W = UADDR_W,
    parameter int WORD_W = UW_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = WORD_W'(store_word(g));
    end

    assign word_o = rom[addr_i];
endmodule

// File: rtl/ucseq_step.sv
module ucseq_step
    import ucseq_pkg::*;
#(
    parameter int OP_W   = OPC_W,
    parameter int ADDR_W = UADDR_W,
    parameter int SW     = STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic              done_i,
    output phase_t            phase_o,
    output logic [ADDR_W-1:0] addr_o
);
    phase_t          phase_q;
    logic [SW-1:0]   step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_q <= PH_FETCH;
                    step_q  <= '0;
                end
                PH_FETCH: begin
                    phase_q <= PH_EXEC;
                    step_q  <= '0;
                end
                PH_EXEC: begin
                    if (done_i) begin
                        phase_q <= PH_FETCH;
                        step_q  <= '0;
                    end else begin
                        step_q  <= step_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    step_q  <= '0;
                end
            endcase
        end
    end

    always_comb begin
        if (phase_q == PH_EXEC)
            addr_o = ADDR_W'(entry_of(OPC_W'(opcode_i))) + ADDR_W'(step_q);
        else
            addr_o = ADDR_W'(FETCH_ADDR);
    end

    assign phase_o = phase_q;

    a_r7_reset_idle: assert property (@(posedge clk)
        rst |=> phase_q == PH_IDLE);

    a_r7_idle_to_fetch: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_IDLE |=> phase_q == PH_FETCH);

    a_r8_fetch_to_entry: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_FETCH |=> (phase_q == PH_EXEC && step_q == '0));

    a_r9_step_advance: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && !done_i)
            |=> (phase_q == PH_EXEC && step_q == SW'($past(step_q) + 1'b1)));

    a_r9_no_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && !done_i) |-> step_q != '1);

    a_r10_end_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC && done_i) |=> phase_q == PH_FETCH);
endmodule

// File: rtl/ucseq_decode.sv
module ucseq_decode
    import ucseq_pkg::*;
#(
    parameter int N_WR  = WR_N,
    parameter int N_RD  = RD_N,
    parameter int N_AU  = AU_N,
    parameter int N_PC  = PC_N,
    parameter int N_ALU = ALU_N
) (
    input  logic             clk,
    input  logic             rst,
    input  uword_t           word_i,
    output logic [N_WR-1:0]  wr_en_o,
    output logic [N_RD-1:0]  rd_en_o,
    output logic [N_AU-1:0]  au_o,
    output logic [N_PC-1:0]  pc_o,
    output logic [N_ALU-1:0] alu_o
);
    for (genvar g = 0; g < N_WR; g++) begin : g_wr
        assign wr_en_o[g] = (word_i.wr == 3'(g + 1));
    end

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_en_o[g] = (word_i.rd == 3'(g + 1));
    end

    for (genvar g = 0; g < N_AU; g++) begin : g_au
        assign au_o[g] = (word_i.au == au_code(g));
    end

    for (genvar g = 0; g < N_PC; g++) begin : g_pc
        assign pc_o[g] = (word_i.pc == 2'(g + 1));
    end

    for (genvar g = 0; g < N_ALU; g++) begin : g_alu
        assign alu_o[g] = (word_i.alu == 4'(g + 1));
    end

    a_r2_write_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en_o));

    a_r3_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_en_o));

    a_r4_au_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(au_o));

    a_r4_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (word_i.au == 3'd0 || word_i.au == 3'd3 || word_i.au == 3'd7) |-> au_o == '0);

    a_r5_pc_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pc_o));

    a_r6_alu_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alu_o));
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
    import ucseq_pkg::*;
#(
    parameter int OP_W   = OPC_W,
    parameter int ADDR_W = UADDR_W,
    parameter int SW     = STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode_i,
    output logic [UW_W-1:0]   uword_o,
    output logic              fetch_o,
    output logic              end_o,
    output logic [WR_N-1:0]   wr_en_o,
    output logic [RD_N-1:0]   rd_en_o,
    output logic [AU_N-1:0]   au_o,
    output logic [PC_N-1:0]   pc_o,
    output logic [ALU_N-1:0]  alu_o
);
    phase_t            phase;
    logic [ADDR_W-1:0] addr;
    logic [UW_W-1:0]   store_word_q;
    uword_t            cur;

    ucseq_step #(
        .OP_W   (OP_W),
        .ADDR_W (ADDR_W),
        .SW     (SW)
    ) u_step (
        .clk      (clk),
        .rst      (rst),
        .opcode_i (opcode_i),
        .done_i   (cur.done),
        .phase_o  (phase),
        .addr_o   (addr)
    );

    ucseq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (UW_W)
    ) u_store (
        .addr_i (addr),
        .word_o (store_word_q)
    );

    assign cur = (phase == PH_IDLE) ? uword_t'(UW_IDLE) : uword_t'(store_word_q);

    ucseq_decode u_decode (
        .clk     (clk),
        .rst     (rst),
        .word_i  (cur),
        .wr_en_o (wr_en_o),
        .rd_en_o (rd_en_o),
        .au_o    (au_o),
        .pc_o    (pc_o),
        .alu_o   (alu_o)
    );

    assign uword_o = cur;
    assign fetch_o = (phase == PH_FETCH);
    assign end_o   = cur.done;

    a_r8_fetch_word: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> (uword_o == UW_FETCH && !end_o));

    a_r8_fetch_one_cycle: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> !fetch_o);

    a_r10_end_then_fetch: assert property (@(posedge clk) disable iff (rst)
        end_o |=> fetch_o);
endmodule

// File: tb/ucseq_top_tb.sv
`timescale 1ns/1ps
module ucseq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'd0;
    logic [15:0] uword;
    logic        fetch, endb;
    logic [5:0]  wr_en;
    logic [6:0]  rd_en;
    logic [4:0]  au;
    logic [2:0]  pc;
    logic [14:0] alu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ucseq_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .opcode_i (opcode),
        .uword_o  (uword),
        .fetch_o  (fetch),
        .end_o    (endb),
        .wr_en_o  (wr_en),
        .rd_en_o  (rd_en),
        .au_o     (au),
        .pc_o     (pc),
        .alu_o    (alu)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Routine length per opcode (R10, R11).
    function automatic int exp_len(int op);
        case (op)
            0, 4, 5, 7: return 1;
            6:          return 3;
            default:    return 2;
        endcase
    endfunction

    // Expected microword i of opcode op (R11).
    function automatic logic [15:0] exp_word(int op, int i);
        int k;
        logic [15:0] w;
        case (op)
            0: w = 16'h0010;
            1: w = (i == 0) ? 16'h7800 : 16'h0010;
            2: w = (i == 0) ? 16'h1680 : 16'hCC10;
            3: w = (i == 0) ? 16'h5800 : 16'h6017;
            4: w = 16'h1450;
            5: w = 16'h1470;
            6: w = (i == 0) ? 16'h3E00 : (i == 1) ? 16'h0080 : 16'h8410;
            7: w = 16'h003F;
            default: begin
                k = op - 8;
                if (i == 0)
                    w = {3'd0, ((k % 2 == 1) ? 3'd4 : 3'd2), 3'd0, 2'd0, 1'b0, 4'(k + 1)};
                else
                    w = {3'd3, 3'd0, ((k % 2 == 1) ? 3'd6 : 3'd2), 2'd0, 1'b1, 4'(k + 8)};
            end
        endcase
        return w;
    endfunction

    function automatic logic [31:0] onehot_of(int c, int lo, int hi);
        if (c >= lo && c <= hi) return 32'(1) << (c - 1);
        return 32'd0;
    endfunction

    function automatic logic [31:0] au_exp(int c);
        case (c)
            1: return 32'h01;
            2: return 32'h02;
            4: return 32'h04;
            5: return 32'h08;
            6: return 32'h10;
            default: return 32'h00;
        endcase
    endfunction

    // Decode of every field group against the issued word (R1..R6, R9).
    task automatic check_strobes();
        logic [15:0] w;
        w = uword;
        chk("R2 write strobes", 32'(wr_en), onehot_of(int'(w[15:13]), 1, 6));
        chk("R3 read enables",  32'(rd_en), onehot_of(int'(w[12:10]), 1, 7));
        chk("R4 address unit",  32'(au),    au_exp(int'(w[9:7])));
        chk("R5 pc actions",    32'(pc),    onehot_of(int'(w[6:5]), 1, 3));
        chk("R6 alu selects",   32'(alu),   onehot_of(int'(w[3:0]), 1, 15));
        chk("R1 R9 end bit",    32'(endb),  32'(w[4]));
    endtask

    task automatic check_idle(string tag);
        chk({tag, " R7 idle word"}, 32'(uword), 32'h0);
        chk({tag, " R7 fetch low"}, 32'(fetch), 32'h0);
        chk({tag, " R7 strobes low"}, 32'({wr_en, rd_en, au, pc, alu, endb}), 32'h0);
    endtask

    task automatic run_op(int op);
        @(negedge clk);
        chk("R8 fetch word", 32'(uword), 32'hB800);
        chk("R8 fetch flag", 32'(fetch), 32'h1);
        check_strobes();
        opcode = 4'(op);
        for (int i = 0; i < exp_len(op); i++) begin
            @(negedge clk);
            chk($sformatf("R11 R9 op%0d word%0d", op, i), 32'(uword), 32'(exp_word(op, i)));
            chk("R9 fetch low in routine", 32'(fetch), 32'h0);
            chk("R10 end only on last word", 32'(endb), 32'(i == exp_len(op) - 1));
            check_strobes();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_idle("held");
        rst = 1'b0;
        check_idle("release");

        // Directed: every opcode, in order and then reversed.
        for (int op = 0; op < 16; op++) run_op(op);
        for (int op = 15; op >= 0; op--) run_op(op);
        // Back-to-back single-word routines.
        run_op(4); run_op(4); run_op(0); run_op(7);

        // Reset in the middle of a three-word routine.
        @(negedge clk);
        chk("R8 fetch before abort", 32'(uword), 32'hB800);
        opcode = 4'd6;
        @(negedge clk);
        chk("R11 op6 first word", 32'(uword), 32'h3E00);
        rst = 1'b1;
        @(negedge clk);
        check_idle("mid-routine");
        rst = 1'b0;
        run_op(6);

        // Random opcode stream.
        for (int n = 0; n < 400; n++) run_op(int'($urandom_range(15, 0)));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule